// File: doc/BRIEF.md
# Serial-Loaded Text Message Buffer

This block takes characters from an asynchronous serial line and keeps them in a small text buffer. A display engine reads that buffer through a separate read port. The serial input is 8 data bits, no parity and one stop bit. It is sampled by an internal receiver whose bit timing comes from the system clock frequency and the baud rate, both of which are parameters. A write controller looks at each received byte. A carriage return moves the write position back to the start and leaves the text alone. An escape fills the whole buffer with spaces in a single cycle and also moves back to the start. Every other byte goes into the next position, and the position wraps after the last entry.

The buffer holds a default message from configuration time onward. The synchronous, active-high reset clears the receiver and the write position but keeps the text. The receiver also reports the bytes it receives, a busy flag and a framing-error pulse, so neighbouring logic can watch the line.

Top module: `serialTextBuf`

## Requirements
- R1: One cycle after `rst` is held high, `rxBusy`, `rxValid` and `rxErr` are 0 and the write position is 0. The next stored character goes to index 0.
- R2: Without any write, the buffer holds the default message "HELLO, SERIAL!  ", with character k at index k. Index 0 reads 0x48 ('H') and index 4 reads 0x4F ('O').
- R3: A received byte other than 0x0D or 0x1B is stored at the current write position, and the position then advances by one.
- R4: With 16 entries, the position after index 15 is index 0. The 17th byte in a row overwrites index 0.
- R5: A received 0x0D (carriage return) changes no entry and sets the write position to 0.
- R6: A received 0x1B (escape) sets all 16 entries to 0x20 (space) on one clock edge and sets the write position to 0.
- R7: The receiver takes a frame as one low start bit, 8 data bits with the least significant bit first, and one stop bit, each sampled at its centre. A frame with a high stop bit gives a `rxValid` pulse of exactly one cycle, with `rxByte` equal to the received value.
- R8: A frame whose stop bit is sampled low gives a one-cycle `rxErr` pulse and no `rxValid`. It leaves the buffer and the write position unchanged, and the receiver waits for the line to go high before it looks for the next start bit.
- R9: `rxBusy` is 1 from the moment a start bit is detected until the frame ends. It is 0 while the line is idle.
- R10: `rdChar` shows the entry selected by `rdIdx` combinationally. During the cycle in which that entry is being written, it still shows the old value.
- R11: `rst` does not bring back the default message or change any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| rdIdx | input | 4 | Character index for the display read |
| rdChar | output | 8 | Character stored at `rdIdx` |
| rxValid | output | 1 | One-cycle pulse when a byte is received |
| rxByte | output | 8 | Last received byte, valid with `rxValid` |
| rxBusy | output | 1 | Receiver is inside a frame |
| rxErr | output | 1 | One-cycle pulse on a framing error |

## Verification
A buffer write and a display read of the same index can happen in the same cycle. The bench provokes this by pointing `rdIdx` at the current write position before it sends a byte. It samples `rdChar` on the falling edge inside the cycle in which `rxValid` is high, and that sample must still be the old character. A read after the following rising edge must give the new character. The escape case also falls on a single edge: one blanking strobe must reach every entry, so the bench checks entries away from the current position.

// File: rtl/serialTextPkg.sv
package serialTextPkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rxState_t;

  typedef struct packed {
    logic wrEn;
    logic clrAll;
  } wrStrobe_t;

  localparam logic [7:0] CHAR_CR    = 8'h0D;
  localparam logic [7:0] CHAR_ESC   = 8'h1B;
  localparam logic [7:0] CHAR_SPACE = 8'h20;

endpackage

// File: rtl/strRecv.sv
module strRecv
  import serialTextPkg::*;
#(
  parameter int CLK_HZ = 12_000_000,
  parameter int BAUD   = 9600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  output logic       rxValid,
  output logic [7:0] rxByte,
  output logic       rxBusy,
  output logic       rxErr
);

  localparam int BIT_CLKS  = CLK_HZ / BAUD;
  localparam int HALF_CLKS = BIT_CLKS / 2;
  localparam int CNT_W     = $clog2(BIT_CLKS + 1);

  rxState_t   state;
  logic [1:0] syncLine;
  logic       lineS;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bitIdx;
  logic [7:0] shiftReg;

  assign lineS  = syncLine[1];
  assign rxByte = shiftReg;
  assign rxBusy = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      syncLine <= 2'b11;
      cnt      <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      rxValid  <= 1'b0;
      rxErr    <= 1'b0;
    end else begin
      syncLine <= {syncLine[0], rxLine};
      rxValid  <= 1'b0;
      rxErr    <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!lineS) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == CNT_W'(HALF_CLKS - 1)) begin
            cnt <= '0;
            if (!lineS) begin
              state  <= RX_DATA;
              bitIdx <= '0;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CNT_W'(BIT_CLKS - 1)) begin
            cnt      <= '0;
            shiftReg <= {lineS, shiftReg[7:1]};
            if (bitIdx == 3'd7) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CNT_W'(BIT_CLKS - 1)) begin
            cnt <= '0;
            if (lineS) begin
              rxValid <= 1'b1;
              state   <= RX_IDLE;
            end else begin
              rxErr <= 1'b1;
              state <= RX_HOLD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HOLD: begin
          if (lineS) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  // R8
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rxValid && rxErr));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rxErr |-> rxBusy);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> !rxBusy);

endmodule

// File: rtl/strCtrl.sv
module strCtrl
  import serialTextPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  output wrStrobe_t        stb,
  output logic [PTR_W-1:0] wrAddr,
  output logic [7:0]       wrData
);

  logic [PTR_W-1:0] wrPtr;
  logic isCr, isEsc;

  assign isCr   = (rxByte == CHAR_CR);
  assign isEsc  = (rxByte == CHAR_ESC);
  assign wrAddr = wrPtr;
  assign wrData = rxByte;

  always_comb begin
    stb.wrEn   = rxValid && !isCr && !isEsc;
    stb.clrAll = rxValid && isEsc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
    end else if (rxValid) begin
      if (isCr || isEsc) wrPtr <= '0;
      else if (wrPtr == PTR_W'(DEPTH - 1)) wrPtr <= '0;
      else wrPtr <= wrPtr + 1'b1;
    end
  end

  // R5
  cr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    (rxValid && rxByte == CHAR_CR) |=> (wrPtr == '0));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && wrPtr != PTR_W'(DEPTH - 1)) |=> (wrPtr == $past(wrPtr) + 1'b1));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && wrPtr == PTR_W'(DEPTH - 1)) |=> (wrPtr == '0));

endmodule

// File: rtl/strStore.sv
module strStore
  import serialTextPkg::*;
#(
  parameter int DEPTH = 16,
  parameter logic [8*DEPTH-1:0] INIT_MSG = "HELLO, SERIAL!  ",
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  wrStrobe_t        stb,
  input  logic [PTR_W-1:0] wrAddr,
  input  logic [7:0]       wrData,
  input  logic [PTR_W-1:0] rdIdx,
  output logic [7:0]       rdChar
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT_MSG[8*(DEPTH-1-i) +: 8];
  end

  always_ff @(posedge clk) begin
    if (stb.clrAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CHAR_SPACE;
    end else if (stb.wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdChar = mem[rdIdx];

  // R6
  blank_all_chk: assert property (@(posedge clk) disable iff (rst)
    stb.clrAll |=> (mem[0] == CHAR_SPACE && mem[DEPTH-1] == CHAR_SPACE));

  // R3
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && !stb.clrAll) |=> (mem[$past(wrAddr)] == $past(wrData)));

endmodule

// File: rtl/serialTextBuf.sv
module serialTextBuf
  import serialTextPkg::*;
#(
  parameter int CLK_HZ = 12_000_000,
  parameter int BAUD   = 9600,
  parameter int DEPTH  = 16,
  parameter logic [8*DEPTH-1:0] INIT_MSG = "HELLO, SERIAL!  ",
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxLine,
  input  logic [PTR_W-1:0] rdIdx,
  output logic [7:0]       rdChar,
  output logic             rxValid,
  output logic [7:0]       rxByte,
  output logic             rxBusy,
  output logic             rxErr
);

  wrStrobe_t        stb;
  logic [PTR_W-1:0] wrAddr;
  logic [7:0]       wrData;

  strRecv #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_recv (
    .clk(clk), .rst(rst), .rxLine(rxLine),
    .rxValid(rxValid), .rxByte(rxByte), .rxBusy(rxBusy), .rxErr(rxErr)
  );

  strCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxByte(rxByte),
    .stb(stb), .wrAddr(wrAddr), .wrData(wrData)
  );

  strStore #(.DEPTH(DEPTH), .INIT_MSG(INIT_MSG)) i_store (
    .clk(clk), .rst(rst), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdIdx(rdIdx), .rdChar(rdChar)
  );

endmodule

// File: tb/test_serialTextBuf.sv
module test_serialTextBuf;

  localparam int BITC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxLine = 1'b1;
  logic [3:0] rdIdx = '0;
  logic [7:0] rdChar, rxByte;
  logic       rxValid, rxBusy, rxErr;

  int checks = 0;
  int fails  = 0;
  int validCnt = 0;
  int errCnt = 0;
  logic [7:0] lastByte = '0;
  logic [7:0] snap = '0;
  logic midBusy = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  serialTextBuf #(.CLK_HZ(80_000), .BAUD(10_000)) i_serialTextBuf (
    .clk(clk), .rst(rst), .rxLine(rxLine), .rdIdx(rdIdx), .rdChar(rdChar),
    .rxValid(rxValid), .rxByte(rxByte), .rxBusy(rxBusy), .rxErr(rxErr)
  );

  always @(negedge clk) begin
    if (!rst && rxValid) begin
      validCnt++;
      lastByte = rxByte;
      snap = rdChar;
    end
    if (!rst && rxErr) errCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit goodStop);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxLine = b[k];
      repeat (BITC) @(negedge clk);
      if (k == 3) midBusy = rxBusy;
    end
    rxLine = goodStop;
    repeat (BITC) @(negedge clk);
    rxLine = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic readAt(input logic [3:0] idx, output logic [7:0] c);
    @(negedge clk);
    rdIdx = idx;
    #1 c = rdChar;
  endtask

  // {byte, probe index, expected char}
  localparam logic [19:0] VEC [8] = '{
    {8'h41, 4'd0, 8'h41},
    {8'h42, 4'd1, 8'h42},
    {8'h0D, 4'd1, 8'h42},
    {8'h43, 4'd0, 8'h43},
    {8'h44, 4'd1, 8'h44},
    {8'h1B, 4'd1, 8'h20},
    {8'h45, 4'd0, 8'h45},
    {8'h46, 4'd2, 8'h20}
  };

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] c;
    int v0, e0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", rxBusy, 0);
    check("R1 valid", rxValid, 0);
    check("R1 err", rxErr, 0);
    // R2 default message
    readAt(4'd0, c); check("R2 idx0", c, 8'h48);
    readAt(4'd4, c); check("R2 idx4", c, 8'h4F);

    // R3 R5 R6 R7 vector walk
    for (int n = 0; n < 8; n++) begin
      v0 = validCnt;
      sendByte(VEC[n][19:12], 1'b1);
      check("R7 one pulse", validCnt - v0, 1);
      check("R7 byte", lastByte, VEC[n][19:12]);
      readAt(VEC[n][11:8], c);
      check((VEC[n][19:12] == 8'h0D) ? "R5 cr" :
            (VEC[n][19:12] == 8'h1B) ? "R6 esc" : "R3 store", c, VEC[n][7:0]);
    end
    // R6 blank far entry
    readAt(4'd15, c); check("R6 idx15 blank", c, 8'h20);
    // R9 busy
    check("R9 busy mid-frame", midBusy, 1);
    check("R9 idle", rxBusy, 0);

    // R8 framing error, pointer is 2
    v0 = validCnt; e0 = errCnt;
    sendByte(8'h51, 1'b0);
    check("R8 err pulse", errCnt - e0, 1);
    check("R8 no valid", validCnt - v0, 0);
    readAt(4'd2, c); check("R8 buffer kept", c, 8'h20);
    sendByte(8'h58, 1'b1);
    readAt(4'd2, c); check("R8 pointer kept", c, 8'h58);

    // R10 same-cycle read and write at index 3
    readAt(4'd3, c);
    sendByte(8'h59, 1'b1);
    check("R10 old value during write", snap, 8'h20);
    readAt(4'd3, c); check("R10 new value after", c, 8'h59);

    // R4 wrap
    sendByte(8'h1B, 1'b1);
    for (int k = 0; k < 16; k++) sendByte(8'h61 + 8'(k), 1'b1);
    sendByte(8'h5A, 1'b1);
    readAt(4'd0, c);  check("R4 wrap idx0", c, 8'h5A);
    readAt(4'd1, c);  check("R4 idx1", c, 8'h62);
    readAt(4'd15, c); check("R4 idx15", c, 8'h70);

    // R1 R11 reset keeps text, rewinds pointer (was 1)
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R1 busy after rst", rxBusy, 0);
    check("R1 valid after rst", rxValid, 0);
    readAt(4'd0, c); check("R11 text kept", c, 8'h5A);
    sendByte(8'h52, 1'b1);
    readAt(4'd0, c); check("R1 pointer zero", c, 8'h52);
    readAt(4'd1, c); check("R1 idx1 untouched", c, 8'h62);

    finishRun();
  end

endmodule